// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from the module clock. It has two divider laws. The power-of-two law divides the module clock by 2^n. The linear law divides it by 2×(m+1). A select bit chooses the law. Along with the clock, the block produces two single-cycle strobes for the shift engine. One marks each rising (leading) serial-clock edge and the other marks each falling (trailing) edge. The shift engine uses them as clock enables in the module-clock domain.

Software writes the law select and both divisor fields through a small write port. The write lands in a holding copy. The running divider takes that copy only at a point where the serial clock is idle: while the bus is disabled, or at the falling edge that ends a period. A change of rate therefore never shortens or stretches a half period in flight. The serial clock is held low until the bus-enable input is set, so enabling the bus cannot produce an early edge. A power-of-two exponent of zero passes the module clock straight through. In that case the output is gated on the low phase of the clock, so the pulses are always whole.

Top module: `sck_divider`

## Requirements
- R1: After reset, sck, leadStb and trailStb are all low.
- R2: While busEn is sampled low, sck stays low and neither strobe is asserted. After busEn rises, sck stays low until the first leading strobe.
- R3: With cfgLinSel = 0 (power-of-two law) and cfgPow = n with n from 1 to 15, sck has a period of 2^n module-clock cycles. Its high and low halves are 2^(n-1) cycles each.
- R4: With cfgLinSel = 1 (linear law), each sck half lasts cfgLin+1 module-clock cycles, giving a period of 2×(cfgLin+1). This covers divides from 2 (cfgLin = 0) to 512 (cfgLin = 255).
- R5: With cfgLinSel = 0 and cfgPow = 0, sck copies the module clock: high in its high phase and low in its low phase. It does so from the first module-clock rising edge that samples busEn high until the first one that samples it low. In every cycle of that span both leadStb and trailStb are high.
- R6: In the divided laws, leadStb is high for exactly the cycle in which sck has just gone high, and trailStb for exactly the cycle in which it has just gone low. The first rising sck edge comes at the H-th module-clock rising edge that samples busEn high, where H is the half-period length.
- R7: A configuration write made while sck is running takes effect at the next falling sck edge. The period in flight keeps its old length.
- R8: If busEn is sampled low in the middle of a period, sck is low from that module-clock edge on, and no trailStb is issued for the cut period.
- R9: A configuration written while busEn is low is in force from the first period after busEn rises. This holds provided two module-clock edges separate the write edge from the edge that first samples busEn high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Write strobe for the holding configuration |
| cfgLinSel | input | 1 | Law select: 1 linear, 0 power-of-two |
| cfgPow | input | POW_W | Power-of-two exponent n (divide by 2^n, 0 = pass-through) |
| cfgLin | input | LIN_W | Linear divisor m (divide by 2×(m+1)) |
| busEn | input | 1 | Bus enable; sck is held low while clear |
| sck | output | 1 | Serial clock, idle low |
| leadStb | output | 1 | One-cycle marker of a rising sck edge |
| trailStb | output | 1 | One-cycle marker of a falling sck edge |

## Verification
The bench checks the extremes of both laws: the smallest half of one cycle, the largest linear divide of 512 and the largest power-of-two divide. An off-by-one in the terminal count would show as every edge drifting from its predicted cycle. It also rewrites the divisor while sck is high and expects the current period to finish at its old length. A design that took the new value at once would move the falling edge. The bench drops the enable mid-period and expects an immediate low sck with no falling strobe, which catches a design that lets the period run out. Finally, it runs the pass-through case, checking both clock phases and the strobes together in every cycle. This catches a gate that clips or leaks a pulse.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

  // Strobes from the control section to the datapath, valid for one cycle.
  typedef struct packed {
    logic run;     // divided law active and bus enabled: counter advances
    logic setHi;   // half period ends with sck low: drive it high
    logic setLo;   // half period ends with sck high: drive it low
    logic passGo;  // pass-through law active and bus enabled
  } sckCtl_t;

endpackage

// File: rtl/sck_div_ctrl.sv
module sck_div_ctrl
  import sck_div_pkg::*;
#(
  parameter int POW_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgLinSel,
  input  logic [POW_W-1:0] cfgPow,
  input  logic [LIN_W-1:0] cfgLin,
  input  logic             busEn,
  input  logic             halfDone,
  output logic             actLinSel,
  output logic [POW_W-1:0] actPow,
  output logic [LIN_W-1:0] actLin,
  output sckCtl_t          ctl,
  output logic             leadStb,
  output logic             trailStb
);

  logic             holdLinSel;
  logic [POW_W-1:0] holdPow;
  logic [LIN_W-1:0] holdLin;
  logic             phase;
  logic             actPass;
  logic             loadCfg;

  // Holding copy written by software at any time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdLinSel <= 1'b0;
      holdPow    <= POW_W'(1);
      holdLin    <= '0;
    end else if (cfgWr) begin
      holdLinSel <= cfgLinSel;
      holdPow    <= cfgPow;
      holdLin    <= cfgLin;
    end
  end

  assign actPass = !actLinSel && (actPow == '0);

  always_comb begin
    ctl.run    = busEn && !actPass;
    ctl.passGo = busEn && actPass;
    ctl.setHi  = ctl.run && halfDone && !phase;
    ctl.setLo  = ctl.run && halfDone && phase;
  end

  // Idle boundaries: bus off, pass-through (every cycle), end of a period.
  assign loadCfg = !busEn || actPass || ctl.setLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLinSel <= 1'b0;
      actPow    <= POW_W'(1);
      actLin    <= '0;
    end else if (loadCfg) begin
      actLinSel <= holdLinSel;
      actPow    <= holdPow;
      actLin    <= holdLin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else begin
      if (!ctl.run)     phase <= 1'b0;
      else if (halfDone) phase <= !phase;
      leadStb  <= ctl.setHi || ctl.passGo;
      trailStb <= ctl.setLo || ctl.passGo;
    end
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase && $past(phase)) |-> ($stable(actLin) && $stable(actPow) && $stable(actLinSel)));

  // R8
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> (!leadStb && !trailStb));

endmodule

// File: rtl/sck_div_dp.sv
module sck_div_dp
  import sck_div_pkg::*;
#(
  parameter int POW_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             actLinSel,
  input  logic [POW_W-1:0] actPow,
  input  logic [LIN_W-1:0] actLin,
  input  sckCtl_t          ctl,
  output logic             halfDone,
  output logic             sckDiv,
  output logic             sck
);

  localparam int POW_HALF_W = (1 << POW_W) - 1;
  localparam int CNT_W = (POW_HALF_W > LIN_W + 1) ? POW_HALF_W : LIN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfMax;
  logic             sckReg;
  logic             passEnNeg;

  always_comb begin
    if (actLinSel)          halfMax = CNT_W'(actLin);
    else if (actPow == '0)  halfMax = '0;
    else                    halfMax = (CNT_W'(1) << (actPow - POW_W'(1))) - CNT_W'(1);
  end

  assign halfDone = (cnt == halfMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (!ctl.run || halfDone) cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sckReg <= 1'b0;
    else if (ctl.setHi)              sckReg <= 1'b1;
    else if (ctl.setLo || !ctl.run)  sckReg <= 1'b0;
  end

  // Gate for the pass-through law changes only while clk is low.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) passEnNeg <= 1'b0;
    else       passEnNeg <= ctl.passGo;
  end

  assign sckDiv = sckReg;
  assign sck    = sckReg | (clk & passEnNeg);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> !sckReg);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= halfMax);

  // R5
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    passEnNeg |-> !sckReg);

endmodule

// File: rtl/sck_divider.sv
module sck_divider
  import sck_div_pkg::*;
#(
  parameter int POW_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgLinSel,
  input  logic [POW_W-1:0] cfgPow,
  input  logic [LIN_W-1:0] cfgLin,
  input  logic             busEn,
  output logic             sck,
  output logic             leadStb,
  output logic             trailStb
);

  sckCtl_t          ctl;
  logic             halfDone;
  logic             actLinSel;
  logic [POW_W-1:0] actPow;
  logic [LIN_W-1:0] actLin;
  logic             sckDiv;

  sck_div_ctrl #(.POW_W(POW_W), .LIN_W(LIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgLinSel(cfgLinSel),
    .cfgPow(cfgPow), .cfgLin(cfgLin), .busEn(busEn), .halfDone(halfDone),
    .actLinSel(actLinSel), .actPow(actPow), .actLin(actLin), .ctl(ctl),
    .leadStb(leadStb), .trailStb(trailStb)
  );

  sck_div_dp #(.POW_W(POW_W), .LIN_W(LIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .actLinSel(actLinSel), .actPow(actPow),
    .actLin(actLin), .ctl(ctl), .halfDone(halfDone), .sckDiv(sckDiv), .sck(sck)
  );

  // R6
  lead_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leadStb && !trailStb) |-> sckDiv);

  // R6
  trail_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trailStb && !leadStb) |-> !sckDiv);

endmodule

// File: tb/sck_divider_bench.sv
module sck_divider_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic       cfgLinSel = 1'b0;
  logic [3:0] cfgPow = '0;
  logic [7:0] cfgLin = '0;
  logic       busEn = 1'b0;
  logic       sck, leadStb, trailStb;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  bit passWin = 1'b0;
  bit done = 1'b0;

  // Scoreboard: expected strobe kind (1 lead, 0 trail), cycle and requirement.
  bit    expLead[$];
  int    expCyc[$];
  string expTag[$];

  sck_divider u_sck_divider (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgLinSel(cfgLinSel),
    .cfgPow(cfgPow), .cfgLin(cfgLin), .busEn(busEn),
    .sck(sck), .leadStb(leadStb), .trailStb(trailStb)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cfgWrite(bit sel, int pw, int ln);
    cfgWr = 1'b1; cfgLinSel = sel; cfgPow = 4'(pw); cfgLin = 8'(ln);
    @(posedge clk); #1;
    cfgWr = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic pushEdge(bit lead, int c, string tag);
    expLead.push_back(lead);
    expCyc.push_back(c);
    expTag.push_back(tag);
  endtask

  task automatic runDiv(int h, int periods, string tag);
    int c;
    c = cyc;
    for (int k = 0; k < periods; k++) begin
      pushEdge(1'b1, c + h + 2 * k * h, tag);
      pushEdge(1'b0, c + 2 * h + 2 * k * h, tag);
    end
    busEn = 1'b1;
    waitCyc(c + 2 * periods * h);
    busEn = 1'b0;
    waitCyc(cyc + 3);
  endtask

  // Monitor: pops expected edges as strobes appear, tracks the sck level.
  initial begin
    bit enS;
    bit lvl;
    lvl = 1'b0;
    forever begin
      @(posedge clk);
      enS = busEn;
      #2;
      if (rstN && !passWin && !done) begin
        if (leadStb || trailStb) begin
          if (expCyc.size() == 0) begin
            chk(1'b0, "R6 unexpected strobe", int'(leadStb), 0);
          end else begin
            bit el;
            int ec;
            string et;
            el = expLead.pop_front();
            ec = expCyc.pop_front();
            et = expTag.pop_front();
            chk(ec == cyc, {et, " edge cycle"}, cyc, ec);
            chk(leadStb == el && trailStb == !el, {et, " strobe kind"},
                int'(leadStb), int'(el));
            lvl = leadStb;
          end
        end
        if (!enS) lvl = 1'b0;
        chk(sck == lvl, enS ? "R6 sck level" : "R2 sck idle", int'(sck), int'(lvl));
      end
    end
  end

  initial begin
    #(150000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    @(posedge clk); #1;
    #1;
    // R1
    chk(sck == 1'b0 && leadStb == 1'b0 && trailStb == 1'b0, "R1 reset state",
        int'({sck, leadStb, trailStb}), 0);
    #8;

    // R2: bus held off with a divided law configured: no edges at all.
    cfgWrite(1'b0, 3, 0);
    waitCyc(cyc + 20);

    // R3 and R9: power-of-two law, written while disabled.
    cfgWrite(1'b0, 1, 0);  runDiv(1, 3, "R3 pow1");
    cfgWrite(1'b0, 3, 0);  runDiv(4, 3, "R9 pow3");
    cfgWrite(1'b0, 5, 0);  runDiv(16, 2, "R3 pow5");
    cfgWrite(1'b0, 15, 0); runDiv(16384, 1, "R3 pow15");

    // R4: linear law, smallest, odd and largest divisors.
    cfgWrite(1'b1, 0, 0);   runDiv(1, 3, "R4 lin0");
    cfgWrite(1'b1, 0, 2);   runDiv(3, 3, "R4 lin2");
    cfgWrite(1'b1, 0, 255); runDiv(256, 2, "R4 lin255");

    // R7: rewrite while sck is high; current period keeps H=4, then H=2.
    cfgWrite(1'b1, 0, 3);
    c = cyc;
    pushEdge(1'b1, c + 4, "R7 old period");
    pushEdge(1'b0, c + 8, "R7 old period");
    pushEdge(1'b1, c + 10, "R7 new period");
    pushEdge(1'b0, c + 12, "R7 new period");
    pushEdge(1'b1, c + 14, "R7 new period");
    pushEdge(1'b0, c + 16, "R7 new period");
    busEn = 1'b1;
    waitCyc(c + 5);
    cfgWr = 1'b1; cfgLinSel = 1'b1; cfgLin = 8'd1;
    @(posedge clk); #1;
    cfgWr = 1'b0;
    waitCyc(c + 16);
    busEn = 1'b0;
    waitCyc(cyc + 3);

    // R8: drop the enable while sck is high.
    cfgWrite(1'b1, 0, 3);
    c = cyc;
    pushEdge(1'b1, c + 4, "R8 lead before cut");
    busEn = 1'b1;
    waitCyc(c + 6);
    busEn = 1'b0;
    waitCyc(c + 7);
    #1;
    chk(sck == 1'b0 && trailStb == 1'b0, "R8 cut period", int'({sck, trailStb}), 0);
    #7;
    waitCyc(c + 14);

    // R5: pass-through law.
    cfgWrite(1'b0, 0, 0);
    passWin = 1'b1;
    c = cyc;
    busEn = 1'b1;
    waitCyc(c + 2);
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(sck == 1'b1 && leadStb && trailStb, "R5 pass high phase",
          int'({sck, leadStb, trailStb}), 7);
      #4;
      chk(sck == 1'b0, "R5 pass low phase", int'(sck), 0);
      #3;
    end
    busEn = 1'b0;
    waitCyc(cyc + 1);
    #1;
    chk(sck == 1'b0 && !leadStb && !trailStb, "R5 pass stop high phase",
        int'({sck, leadStb, trailStb}), 0);
    #4;
    chk(sck == 1'b0, "R5 pass stop low phase", int'(sck), 0);
    #3;
    waitCyc(cyc + 3);
    passWin = 1'b0;
    waitCyc(cyc + 4);

    done = 1'b1;
    chk(expCyc.size() == 0, "R6 missing edges", expCyc.size(), 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule